// File: doc/BRIEF.md
# Repeated String Operation Sequencer

This block runs one string primitive over and over under a repeat prefix. The primitive can be a move, compare, scan, load or store. The block holds three working registers: a source index, a destination index and an element count. A start pulse loads all three together with the operation, the prefix kind, the element size and the direction. After that the block makes one memory element access per iteration over a request/acknowledge handshake.

Each acknowledge ends one iteration. On that acknowledge the block does three things:
- it decrements the count by one;
- it steps the indices that the operation uses, by the element size, up or down;
- it decides whether to stop.

Compare and scan can also end early. The environment returns a comparison zero flag with each acknowledge, and the block stops on it according to the prefix kind. When the run ends, a one-cycle done pulse is raised, and the final index and count values stay on the outputs until the next start.

Top module: `strop_seq`

## Requirements
- R1: After reset the block is idle: `mem_req`, `mem_rd`, `mem_wr`, `busy` and `done` are all low.
- R2: A start pulse seen while idle with a non-zero `cnt_init` loads the three registers and raises `mem_req` on the next cycle. `mem_req` stays high, with indices and count unchanged, until `mem_ack`. The strobes per operation code are:
  - move (`op`=0): read and write;
  - compare (1): read;
  - scan (2): read;
  - load (3): read;
  - store (4): write;
  - codes 5 to 7 behave as move.
- R3: Every cycle with `mem_req` and `mem_ack` high completes one iteration and decrements `cnt` by one.
- R4: An index that moves steps by 1 when `wide`=0 and by 2 when `wide`=1. It increases when `dir_dn`=0 and decreases when `dir_dn`=1.
- R5: Move and compare step both indices. Scan and store step only `dst_idx`. Load steps only `src_idx`.
- R6: Prefix kinds 0 and 3 (plain repeat) run until `cnt` reaches zero, whatever `cmp_zf` is.
- R7: Prefix kind 1 (repeat while equal) with compare or scan also ends after an iteration acknowledged with `cmp_zf`=0.
- R8: Prefix kind 2 (repeat while not equal) with compare or scan also ends after an iteration acknowledged with `cmp_zf`=1.
- R9: Move, load and store ignore `cmp_zf` under every prefix kind and run until `cnt` reaches zero.
- R10: A start with `cnt_init`=0 performs no access. `done` is high in the cycle after the start edge.
- R11: `done` is high for exactly one cycle, starting the cycle after the last iteration's acknowledge. The final indices and count hold until the next start, and a start pulse seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| op | input | 3 | Operation code (see R2) |
| rep_kind | input | 2 | Prefix kind: 0/3 plain, 1 while equal, 2 while not equal |
| wide | input | 1 | Element size: 0 byte, 1 word |
| dir_dn | input | 1 | Direction: 0 increment, 1 decrement |
| src_init | input | AW | Initial source index |
| dst_init | input | AW | Initial destination index |
| cnt_init | input | CW | Initial element count |
| mem_ack | input | 1 | Memory acknowledge, ends one iteration |
| cmp_zf | input | 1 | Comparison zero flag, valid with `mem_ack` |
| mem_req | output | 1 | Memory access request |
| mem_rd | output | 1 | Read strobe, qualified by `mem_req` |
| mem_wr | output | 1 | Write strobe, qualified by `mem_req` |
| src_idx | output | AW | Source index (current access address / final value) |
| dst_idx | output | AW | Destination index (current access address / final value) |
| cnt | output | CW | Remaining count |
| busy | output | 1 | High from the cycle after start until done |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the following on every cycle:
- the request and registers stay frozen while an access waits for its acknowledge;
- every acknowledge lowers the count by exactly one;
- a pending request always carries at least one strobe;
- a zero-count start goes straight to done;
- done never lasts two cycles;
- a plain-repeat run always finishes with a zero count.

Some behaviours can only be shown by the bench's scenarios:
- early exit on the zero flag under the two conditional prefixes;
- that move, load and store ignore that flag;
- which index moves for each operation, and by how much in each direction;
- the exact iteration count at which each run stops;
- that a start arriving mid-run is ignored.

// File: rtl/strop_pkg.sv
package strop_pkg;

    localparam logic [2:0] OPC_MOVE  = 3'd0;
    localparam logic [2:0] OPC_CMP   = 3'd1;
    localparam logic [2:0] OPC_SCAN  = 3'd2;
    localparam logic [2:0] OPC_LOAD  = 3'd3;
    localparam logic [2:0] OPC_STORE = 3'd4;

    localparam logic [1:0] RK_PLAIN  = 2'd0;
    localparam logic [1:0] RK_WHILEQ = 2'd1;
    localparam logic [1:0] RK_WHILNE = 2'd2;
    localparam logic [1:0] RK_PLAIN2 = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_FIN  = 2'd2
    } seq_st_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic src_mv;
        logic dst_mv;
        logic uses_zf;
    } op_attr_t;

endpackage

// File: rtl/strop_dec.sv
module strop_dec
    import strop_pkg::*;
(
    input  logic [2:0] op,
    output op_attr_t   attr
);
    always_comb begin
        attr = '{rd: 1'b1, wr: 1'b1, src_mv: 1'b1, dst_mv: 1'b1, uses_zf: 1'b0};
        unique case (op)
            OPC_CMP:   attr = '{rd: 1'b1, wr: 1'b0, src_mv: 1'b1, dst_mv: 1'b1, uses_zf: 1'b1};
            OPC_SCAN:  attr = '{rd: 1'b1, wr: 1'b0, src_mv: 1'b0, dst_mv: 1'b1, uses_zf: 1'b1};
            OPC_LOAD:  attr = '{rd: 1'b1, wr: 1'b0, src_mv: 1'b1, dst_mv: 1'b0, uses_zf: 1'b0};
            OPC_STORE: attr = '{rd: 1'b0, wr: 1'b1, src_mv: 1'b0, dst_mv: 1'b1, uses_zf: 1'b0};
            default:   attr = '{rd: 1'b1, wr: 1'b1, src_mv: 1'b1, dst_mv: 1'b1, uses_zf: 1'b0};
        endcase
    end
endmodule

// File: rtl/strop_step.sv
module strop_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] idx,
    input  logic          en,
    input  logic          wide,
    input  logic          dn,
    output logic [AW-1:0] nxt
);
    localparam int PADW = AW - 2;

    logic [AW-1:0] step;

    always_comb begin
        step = {{PADW{1'b0}}, wide, ~wide};
        if (!en)
            nxt = idx;
        else if (dn)
            nxt = idx - step;
        else
            nxt = idx + step;
    end
endmodule

// File: rtl/strop_term.sv
module strop_term
    import strop_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic [CW-1:0] cnt_nxt,
    input  logic [1:0]    kind,
    input  logic          uses_zf,
    input  logic          zf,
    output logic          stop
);
    logic early;

    always_comb begin
        early = 1'b0;
        if (uses_zf) begin
            case (kind)
                RK_WHILEQ: early = ~zf;
                RK_WHILNE: early = zf;
                default:   early = 1'b0;
            endcase
        end
        stop = (cnt_nxt == '0) || early;
    end
endmodule

// File: rtl/strop_seq.sv
module strop_seq
    import strop_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op,
    input  logic [1:0]    rep_kind,
    input  logic          wide,
    input  logic          dir_dn,
    input  logic [AW-1:0] src_init,
    input  logic [AW-1:0] dst_init,
    input  logic [CW-1:0] cnt_init,
    input  logic          mem_ack,
    input  logic          cmp_zf,
    output logic          mem_req,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] src_idx,
    output logic [AW-1:0] dst_idx,
    output logic [CW-1:0] cnt,
    output logic          busy,
    output logic          done
);
    typedef struct packed {
        seq_st_e       st;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
        logic [2:0]    op;
        logic [1:0]    kind;
        logic          wide;
        logic          dn;
    } seq_t;

    seq_t st_d, st_q;

    op_attr_t      attr;
    logic [AW-1:0] src_nxt, dst_nxt;
    logic [CW-1:0] cnt_nxt;
    logic          stop;
    logic          adv;

    strop_dec u_dec (
        .op   (st_q.op),
        .attr (attr)
    );

    strop_step #(.AW(AW)) u_src_step (
        .idx  (st_q.src),
        .en   (attr.src_mv),
        .wide (st_q.wide),
        .dn   (st_q.dn),
        .nxt  (src_nxt)
    );

    strop_step #(.AW(AW)) u_dst_step (
        .idx  (st_q.dst),
        .en   (attr.dst_mv),
        .wide (st_q.wide),
        .dn   (st_q.dn),
        .nxt  (dst_nxt)
    );

    assign cnt_nxt = st_q.cnt - 1'b1;

    strop_term #(.CW(CW)) u_term (
        .cnt_nxt (cnt_nxt),
        .kind    (st_q.kind),
        .uses_zf (attr.uses_zf),
        .zf      (cmp_zf),
        .stop    (stop)
    );

    assign adv = (st_q.st == ST_ACC) && mem_ack;

    always_comb begin
        st_d = st_q;
        unique case (st_q.st)
            ST_IDLE: begin
                if (start) begin
                    st_d.src  = src_init;
                    st_d.dst  = dst_init;
                    st_d.cnt  = cnt_init;
                    st_d.op   = op;
                    st_d.kind = rep_kind;
                    st_d.wide = wide;
                    st_d.dn   = dir_dn;
                    st_d.st   = (cnt_init == '0) ? ST_FIN : ST_ACC;
                end
            end
            ST_ACC: begin
                if (adv) begin
                    st_d.src = src_nxt;
                    st_d.dst = dst_nxt;
                    st_d.cnt = cnt_nxt;
                    if (stop)
                        st_d.st = ST_FIN;
                end
            end
            ST_FIN:  st_d.st = ST_IDLE;
            default: st_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{st: ST_IDLE, src: '0, dst: '0, cnt: '0, op: '0,
                      kind: '0, wide: 1'b0, dn: 1'b0};
        else
            st_q <= st_d;
    end

    assign mem_req = (st_q.st == ST_ACC);
    assign mem_rd  = mem_req && attr.rd;
    assign mem_wr  = mem_req && attr.wr;
    assign src_idx = st_q.src;
    assign dst_idx = st_q.dst;
    assign cnt     = st_q.cnt;
    assign busy    = (st_q.st != ST_IDLE);
    assign done    = (st_q.st == ST_FIN);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(src_idx) && $stable(dst_idx) && $stable(cnt))); // R2
    AST_STROBE_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_rd || mem_wr)); // R2
    AST_CNT_DECR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (cnt == $past(cnt) - 1'b1)); // R3
    AST_PLAIN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (st_q.kind == RK_PLAIN || st_q.kind == RK_PLAIN2)) |-> (cnt == '0)); // R6
    AST_ZERO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && cnt_init == '0) |=> (done && !mem_req)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

endmodule

// File: tb/strop_seq_bench.sv
`timescale 1ns/1ps
module strop_seq_bench;
    localparam int AW = 16;
    localparam int CW = 16;
    localparam int NV = 11;
    localparam logic [AW-1:0] SRC0 = 16'h1000;
    localparam logic [AW-1:0] DST0 = 16'h2000;

    // op, kind, wide, dir, count, zf pattern (bit i = iteration i), expected iterations
    localparam int V_OP   [NV] = '{0, 0, 1, 2, 3, 4, 1, 2, 1, 1, 0};
    localparam int V_KIND [NV] = '{0, 0, 1, 2, 1, 2, 1, 1, 0, 3, 0};
    localparam int V_WIDE [NV] = '{0, 1, 0, 1, 0, 1, 1, 0, 0, 1, 0};
    localparam int V_DN   [NV] = '{0, 1, 0, 0, 1, 0, 1, 0, 0, 0, 0};
    localparam int V_CNT  [NV] = '{4, 3, 5, 6, 3, 2, 4, 3, 2, 3, 0};
    localparam int V_ZF   [NV] = '{0, 0, 'h1B, 'h08, 0, 'hFFFF, 'hFFFF, 0, 0, 'hFFFF, 0};
    localparam int V_IT   [NV] = '{4, 3, 3, 4, 3, 2, 4, 1, 2, 3, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] op = '0;
    logic [1:0] rep_kind = '0;
    logic wide = 1'b0, dir_dn = 1'b0;
    logic [AW-1:0] src_init = SRC0, dst_init = DST0;
    logic [CW-1:0] cnt_init = '0;
    logic mem_ack = 1'b0, cmp_zf = 1'b0;
    logic mem_req, mem_rd, mem_wr, busy, done;
    logic [AW-1:0] src_idx, dst_idx;
    logic [CW-1:0] cnt;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    strop_seq #(.AW(AW), .CW(CW)) u_strop_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .rep_kind(rep_kind),
        .wide(wide), .dir_dn(dir_dn), .src_init(src_init), .dst_init(dst_init),
        .cnt_init(cnt_init), .mem_ack(mem_ack), .cmp_zf(cmp_zf),
        .mem_req(mem_req), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .src_idx(src_idx), .dst_idx(dst_idx), .cnt(cnt), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_idx(input logic [AW-1:0] base, input bit mv,
                                              input int w, input int dn, input int k);
        int delta;
        delta = mv ? k * (w ? 2 : 1) : 0;
        return dn ? base - AW'(delta) : base + AW'(delta);
    endfunction

    task automatic run(input int vop, input int vkind, input int vw, input int vdn,
                       input int vcnt, input int vzf, input int vit, input bit spur);
        int n;
        bit seen_done, seen_req, src_mv, dst_mv, exp_rd, exp_wr, got_rd, got_wr;
        // R5: per-operation index movement, R2: strobes
        src_mv = (vop == 0 || vop == 1 || vop == 3 || vop > 4);
        dst_mv = (vop == 0 || vop == 1 || vop == 2 || vop == 4 || vop > 4);
        exp_rd = (vop != 4);
        exp_wr = (vop == 0 || vop == 4 || vop > 4);
        @(negedge clk);
        op = 3'(vop); rep_kind = 2'(vkind); wide = vw[0]; dir_dn = vdn[0];
        src_init = SRC0; dst_init = DST0; cnt_init = CW'(vcnt); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0; seen_done = 0; seen_req = 0; got_rd = 0; got_wr = 0;
        for (int t = 0; t < 200; t++) begin
            if (t > 0) @(negedge clk);
            start = 1'b0;
            if (done) begin seen_done = 1; break; end
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (!seen_req) begin got_rd = mem_rd; got_wr = mem_wr; end
                seen_req = 1;
                // R4: index at iteration n
                chk(src_idx == exp_idx(SRC0, src_mv, vw, vdn, n), "R4 src step", src_idx,
                    exp_idx(SRC0, src_mv, vw, vdn, n));
                chk(dst_idx == exp_idx(DST0, dst_mv, vw, vdn, n), "R4 dst step", dst_idx,
                    exp_idx(DST0, dst_mv, vw, vdn, n));
                if (spur && n == 1) begin
                    start = 1'b1; cnt_init = CW'(99); src_init = '0;
                end
                cmp_zf = vzf[n];
                mem_ack = 1'b1;
                n++;
            end
        end
        mem_ack = 1'b0;
        chk(seen_done, "R11 done seen", int'(seen_done), 1);
        chk(n == vit, "R6 R7 R8 R9 iterations", n, vit);
        chk(cnt == CW'(vcnt - vit), "R3 final count", cnt, vcnt - vit);
        chk(src_idx == exp_idx(SRC0, src_mv, vw, vdn, vit), "R5 final src", src_idx,
            exp_idx(SRC0, src_mv, vw, vdn, vit));
        chk(dst_idx == exp_idx(DST0, dst_mv, vw, vdn, vit), "R5 final dst", dst_idx,
            exp_idx(DST0, dst_mv, vw, vdn, vit));
        if (vit > 0) begin
            chk(got_rd == exp_rd, "R2 read strobe", int'(got_rd), int'(exp_rd));
            chk(got_wr == exp_wr, "R2 write strobe", int'(got_wr), int'(exp_wr));
        end else begin
            chk(!seen_req, "R10 no access", int'(seen_req), 0);
        end
        @(negedge clk);
        chk(!done && !busy, "R11 done one cycle", int'(done), 0);
        chk(cnt == CW'(vcnt - vit), "R11 count held", cnt, vcnt - vit);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!mem_req && !mem_rd && !mem_wr, "R1 no request in reset", int'(mem_req), 0);
        chk(!busy && !done, "R1 idle in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_req, "R1 idle after reset", int'(busy), 0);

        for (int v = 0; v < NV; v++)
            run(V_OP[v], V_KIND[v], V_WIDE[v], V_DN[v], V_CNT[v], V_ZF[v], V_IT[v], 1'b0);

        // R10: zero count, done exactly one cycle after the start edge
        @(negedge clk);
        op = 3'd1; rep_kind = 2'd1; cnt_init = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done && !mem_req, "R10 immediate done", int'(done), 1);

        // R11: start while busy is ignored
        run(0, 0, 0, 0, 3, 0, 3, 1'b1);

        // R2: request held without acknowledge
        @(negedge clk);
        op = 3'd4; rep_kind = 2'd0; wide = 1'b1; dir_dn = 1'b0; cnt_init = CW'(2);
        src_init = SRC0; dst_init = DST0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        chk(mem_req && mem_wr && !mem_rd, "R2 request held", int'(mem_req), 1);
        chk(cnt == CW'(2) && dst_idx == DST0, "R2 no step without ack", cnt, 2);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!mem_req && !busy, "R1 reset aborts run", int'(mem_req), 0);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end
endmodule